// File: doc/BRIEF.md
# Programmable Trigger Delay Block

This block turns a rising edge on one of several trigger lines into one or two strobes that follow the edge after programmed delays. A register-style write port selects the trigger line, a clock prescaler, the run mode and the output arrangement. It also sets a terminal count and two delay values. When an accepted edge arrives, a 16-bit counter restarts from zero. It advances once per prescaled period. Each delay output is high for the one period in which the count equals that output's delay value.

In single-shot mode the block accepts one edge for each arm strobe, and the count then stays at its terminal value. In continuous mode every rising edge restarts the count, and the count returns to zero when it reaches its terminal value. The two strobes can be merged onto one output. A bypass setting sends the selected trigger level straight to the outputs, and the counter stays idle. A typical use is a timing window for an analog comparator, placed a fixed time after a system event.

Top module: `trig_delay_gen`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` at the next clock edge into the register picked by `cfg_addr`. Address 0 is control, 1 is terminal count, 2 is delay A and 3 is delay B. Control bit 0 is enable, bit 1 is continuous mode, bit 2 is bypass, bit 3 is merge, bits 6:4 are the prescaler select and bits 9:7 are the trigger select. Bit 15 of a control write is an arm strobe and is not stored. After reset every register is zero and both outputs are low.
- R2: The trigger used is `trig_i[sel]`, where sel is the trigger select field. Changes on other lines have no effect. A select value of `NUM_TRIG` or above chooses no trigger.
- R3: A start needs all of the following: enable is set, bypass is clear, and the selected line is high at a clock edge after being low at the previous edge. The count is zero from that edge on. A falling edge or a steady high level starts nothing.
- R4: In single-shot mode (control bit 1 clear) a start also needs a pending arm. Each start uses up the arm, so later edges are ignored until the next arm strobe.
- R5: In continuous mode every qualifying rising edge starts the count from zero, even while a count is in progress. No arm is needed.
- R6: The count advances once every 2^p clock cycles, where p is the prescaler select (0 to 7). The prescaler restarts with each start.
- R7: The run ends after the count has spent one prescaled period at the terminal value. In single-shot mode the count then holds. In continuous mode it returns to zero. In both modes it waits for the next start.
- R8: With merge and bypass clear, `dly_o[0]` is high exactly while a run is in progress and the count equals delay A, and `dly_o[1]` does the same for delay B. Each strobe therefore lasts one prescaled period. A delay above the terminal value never produces a strobe.
- R9: With merge set, `dly_o[0]` is the OR of the two strobes and `dly_o[1]` is low.
- R10: With enable and bypass set, both outputs follow the selected trigger level in the same cycle, with no clock delay, and no count starts. If merge is also set, only `dly_o[0]` follows the trigger.
- R11: With enable clear, no count starts, a run in progress stops, and both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | CNT_W | Configuration write data |
| trig_i | input | NUM_TRIG | Trigger inputs |
| dly_o | output | 2 | Delay strobes A (bit 0) and B (bit 1) |

## Verification
The assertions check, on every cycle, the following:
- a run begins only after a detected rising edge;
- an edge detect never fires on two cycles in a row;
- the count moves by exactly one per prescaled tick and stays put while idle;
- the terminal tick ends the run;
- a single-shot start uses up the arm;
- no strobe appears outside a run unless bypass is set.

The exact cycle on which each strobe starts and ends can only be shown by the bench's scenarios. So can:
- the prescaler ratio;
- a mid-run restart in continuous mode;
- ignored triggers after a single-shot run;
- falling edges and unselected lines;
- the same-cycle bypass path and the merged output.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam int unsigned TSEL_W      = 3;
  localparam int unsigned PRESC_SEL_W = 3;
  localparam int unsigned PRESC_CNT_W = (1 << PRESC_SEL_W) - 1;
  localparam int unsigned NUM_CH      = 2;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_TERM    = 2'd1,
    REG_DELAY_A = 2'd2,
    REG_DELAY_B = 2'd3
  } reg_addr_e;

  localparam int unsigned ARM_BIT = 15;

  typedef struct packed {
    logic [TSEL_W-1:0]      trig_sel;
    logic [PRESC_SEL_W-1:0] presc_sel;
    logic                   merge;
    logic                   bypass;
    logic                   continuous;
    logic                   enable;
  } ctrl_t;

  // last value of the prescaler counter for a divide by 2^sel
  function automatic logic [PRESC_CNT_W-1:0] presc_last(input logic [PRESC_SEL_W-1:0] sel);
    logic [PRESC_CNT_W-1:0] one;
    one = PRESC_CNT_W'(1);
    return (one << sel) - one;
  endfunction

  // strobe condition for one delay channel
  function automatic logic delay_hit(input logic running, input logic [15:0] count,
                                     input logic [15:0] delay);
    return running && (count == delay);
  endfunction
endpackage

// File: rtl/tdg_cfg_regs.sv
module tdg_cfg_regs
  import tdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output ctrl_t            ctrl,
  output logic             arm_pulse,
  output logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] delay_a,
  output logic [CNT_W-1:0] delay_b
);
  logic ctrl_wr;
  assign ctrl_wr   = we && (addr == REG_CTRL);
  assign arm_pulse = ctrl_wr && wdata[ARM_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      term    <= '0;
      delay_a <= '0;
      delay_b <= '0;
    end else if (we) begin
      case (addr)
        REG_CTRL: begin
          ctrl.enable     <= wdata[0];
          ctrl.continuous <= wdata[1];
          ctrl.bypass     <= wdata[2];
          ctrl.merge      <= wdata[3];
          ctrl.presc_sel  <= wdata[6:4];
          ctrl.trig_sel   <= wdata[9:7];
        end
        REG_TERM:    term    <= wdata;
        REG_DELAY_A: delay_a <= wdata;
        default:     delay_b <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/tdg_trig_front.sv
module tdg_trig_front
  import tdg_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [TSEL_W-1:0]   sel,
  output logic                sel_lvl,
  output logic                rise
);
  logic prev_q;

  always_comb begin
    sel_lvl = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (sel == TSEL_W'(i)) sel_lvl = trig_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_lvl;
  end

  assign rise = sel_lvl && !prev_q;

  // R3
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tdg_timebase.sv
module tdg_timebase
  import tdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   continuous,
  input  logic                   bypass,
  input  logic [PRESC_SEL_W-1:0] presc_sel,
  input  logic [CNT_W-1:0]       term,
  input  logic                   arm_i,
  input  logic                   rise_i,
  output logic                   running,
  output logic [CNT_W-1:0]       count
);
  logic                   armed_q;
  logic [PRESC_CNT_W-1:0] pre_q;
  logic                   start;
  logic                   tick;
  logic                   at_end;

  assign start  = enable && !bypass && rise_i && (continuous || armed_q);
  assign tick   = running && (pre_q == presc_last(presc_sel));
  assign at_end = tick && (count == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      running <= 1'b0;
      count   <= '0;
      pre_q   <= '0;
    end else begin
      if (start) armed_q <= 1'b0;
      if (arm_i) armed_q <= 1'b1;
      if (!enable) begin
        running <= 1'b0;
        pre_q   <= '0;
      end else if (start) begin
        running <= 1'b1;
        count   <= '0;
        pre_q   <= '0;
      end else if (running) begin
        if (tick) begin
          pre_q <= '0;
          if (at_end) begin
            running <= 1'b0;
            if (continuous) count <= '0;
          end else begin
            count <= count + CNT_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRESC_CNT_W'(1);
        end
      end
    end
  end

  // R3
  start_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(rise_i));

  // R4
  single_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !continuous) |=> (!armed_q || $past(arm_i)));

  // R6
  presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc_sel != '0 && !start) |=> (!tick || presc_sel == '0));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_end && !start && enable) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

  // R7
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !start) |=> !running);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
endmodule

// File: rtl/tdg_out_stage.sv
module tdg_out_stage
  import tdg_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                          enable,
  input  logic                          bypass,
  input  logic                          merge,
  input  logic                          trig_lvl,
  input  logic                          running,
  input  logic [CNT_W-1:0]              count,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  delays,
  output logic [NUM_CH-1:0]             dly_o
);
  logic [NUM_CH-1:0] pulse;
  logic [NUM_CH-1:0] raw;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign pulse[ch] = delay_hit(running, 16'(count), 16'(delays[ch]));
    assign raw[ch]   = enable && (bypass ? trig_lvl : pulse[ch]);
    if (ch == 0) begin : g_first
      assign dly_o[ch] = merge ? (|raw) : raw[ch];
    end else begin : g_rest
      assign dly_o[ch] = merge ? 1'b0 : raw[ch];
    end
  end
endmodule

// File: rtl/trig_delay_gen.sv
module trig_delay_gen
  import tdg_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned NUM_TRIG = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [CNT_W-1:0]    cfg_wdata,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic [1:0]          dly_o
);
  ctrl_t                       ctrl;
  logic                        arm_pulse;
  logic [CNT_W-1:0]            term;
  logic [CNT_W-1:0]            delay_a;
  logic [CNT_W-1:0]            delay_b;
  logic                        sel_lvl;
  logic                        rise;
  logic                        running;
  logic [CNT_W-1:0]            count;
  logic [NUM_CH-1:0][CNT_W-1:0] delays;

  assign delays = {delay_b, delay_a};

  tdg_cfg_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ctrl(ctrl), .arm_pulse(arm_pulse), .term(term), .delay_a(delay_a), .delay_b(delay_b)
  );

  tdg_trig_front #(.NUM_TRIG(NUM_TRIG)) u_front (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .sel(ctrl.trig_sel),
    .sel_lvl(sel_lvl), .rise(rise)
  );

  tdg_timebase #(.CNT_W(CNT_W)) u_time (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.enable), .continuous(ctrl.continuous),
    .bypass(ctrl.bypass), .presc_sel(ctrl.presc_sel), .term(term), .arm_i(arm_pulse),
    .rise_i(rise), .running(running), .count(count)
  );

  tdg_out_stage #(.CNT_W(CNT_W)) u_out (
    .enable(ctrl.enable), .bypass(ctrl.bypass), .merge(ctrl.merge), .trig_lvl(sel_lvl),
    .running(running), .count(count), .delays(delays), .dly_o(dly_o)
  );

  // R8
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dly_o) && !ctrl.bypass) |-> running);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |-> (dly_o == 2'b00));
endmodule

// File: tb/tb_trig_delay_gen.sv
`timescale 1ns/1ps
module tb_trig_delay_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [6:0]  trig = 7'd0;
  logic [1:0]  dly_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_delay_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_i(trig), .dly_o(dly_o)
  );

  typedef struct packed {
    logic [2:0]  p;
    logic [15:0] term;
    logic [15:0] da;
    logic [15:0] db;
    logic        mrg;
    logic        cont;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 16'd5, 16'd2, 16'd4, 1'b0, 1'b0},
    '{3'd1, 16'd3, 16'd0, 16'd3, 1'b0, 1'b0},
    '{3'd2, 16'd4, 16'd1, 16'd1, 1'b0, 1'b1},
    '{3'd0, 16'd6, 16'd1, 16'd5, 1'b1, 1'b0},
    '{3'd3, 16'd2, 16'd2, 16'd9, 1'b0, 1'b1},
    '{3'd7, 16'd1, 16'd1, 16'd0, 1'b1, 1'b0}
  };

  function automatic logic [15:0] cw(bit en, bit cont, bit byp, bit mrg, int p, int ts, bit arm);
    logic [15:0] w;
    w = '0;
    w[0] = en; w[1] = cont; w[2] = byp; w[3] = mrg;
    w[6:4] = 3'(p); w[9:7] = 3'(ts); w[15] = arm;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dly_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input int line);
    trig[line] = 1'b1;
    @(posedge clk);
  endtask

  // sample k cycles after the start edge and compare with the delay model
  task automatic run_window(input string tag, input int p, input int term, input int da,
                            input int db, input bit mrg);
    int d;
    int len;
    d = 1 << p;
    len = (term + 1) * d + 2;
    for (int k = 0; k < len; k++) begin
      logic ea;
      logic eb;
      logic [1:0] e;
      ea = (k < (term + 1) * d) && ((k / d) == da);
      eb = (k < (term + 1) * d) && ((k / d) == db);
      e = mrg ? {1'b0, ea | eb} : {eb, ea};
      @(negedge clk);
      chk(tag, dly_o, e);
    end
  endtask

  task automatic quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, dly_o, 2'b00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", dly_o, 2'b00);
    rst_n = 1'b1;
    // R11: after reset enable is clear, a trigger edge has no effect
    trig[0] = 1'b1;
    quiet("R11 after reset", 6);
    trig = '0;
    @(negedge clk);

    // table of single runs: R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int ts;
      v = VECS[i];
      ts = i % 7;
      wr(2'd1, v.term);
      wr(2'd2, v.da);
      wr(2'd3, v.db);
      wr(2'd0, cw(1, v.cont, 0, v.mrg, int'(v.p), ts, 1));
      fire(ts);
      run_window(v.mrg ? "R9 R6 R7" : "R8 R6 R7", int'(v.p), int'(v.term),
                 int'(v.da), int'(v.db), v.mrg);
      trig = '0;
      @(negedge clk);
    end

    // R5: continuous restart in the middle of a run
    wr(2'd1, 16'd8);
    wr(2'd2, 16'd2);
    wr(2'd3, 16'd7);
    wr(2'd0, cw(1, 1, 0, 0, 0, 0, 0));
    fire(0);
    repeat (4) @(negedge clk);
    trig[0] = 1'b0;
    @(negedge clk);
    fire(0);
    run_window("R5 restart", 0, 8, 2, 7, 0);
    // R7: continuous mode runs again with no arm after returning to zero
    trig[0] = 1'b0;
    @(negedge clk);
    fire(0);
    run_window("R7 R5 rerun", 0, 8, 2, 7, 0);
    // R3: falling edge starts nothing
    trig[0] = 1'b0;
    quiet("R3 falling", 12);

    // R2: unselected line and out-of-range select
    wr(2'd0, cw(1, 1, 0, 0, 0, 2, 0));
    trig[5] = 1'b1;
    quiet("R2 other line", 12);
    trig = '0;
    @(negedge clk);
    wr(2'd0, cw(1, 1, 0, 0, 0, 7, 0));
    trig = '1;
    quiet("R2 select 7", 12);
    trig = '0;
    @(negedge clk);

    // R11: enable clear
    wr(2'd0, cw(0, 1, 0, 0, 0, 0, 0));
    trig[0] = 1'b1;
    quiet("R11 disabled", 12);
    trig = '0;
    @(negedge clk);

    // R4: single-shot needs a new arm for each run
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd1);
    wr(2'd3, 16'd2);
    wr(2'd0, cw(1, 0, 0, 0, 0, 1, 1));
    fire(1);
    run_window("R4 armed", 0, 3, 1, 2, 0);
    trig[1] = 1'b0;
    @(negedge clk);
    fire(1);
    quiet("R4 not rearmed", 8);
    trig[1] = 1'b0;
    @(negedge clk);
    wr(2'd0, cw(1, 0, 0, 0, 0, 1, 1));
    fire(1);
    run_window("R4 rearmed", 0, 3, 1, 2, 0);
    trig = '0;
    @(negedge clk);

    // R10: bypass follows the selected level in the same cycle
    wr(2'd0, cw(1, 0, 1, 0, 0, 3, 1));
    trig[3] = 1'b1;
    #1 chk("R10 bypass high", dly_o, 2'b11);
    @(negedge clk);
    trig[3] = 1'b0;
    #1 chk("R10 bypass low", dly_o, 2'b00);
    @(negedge clk);
    trig[4] = 1'b1;
    #1 chk("R10 R2 bypass other line", dly_o, 2'b00);
    @(negedge clk);
    trig = '0;
    wr(2'd0, cw(1, 0, 1, 1, 0, 3, 0));
    trig[3] = 1'b1;
    #1 chk("R10 bypass merged", dly_o, 2'b01);
    @(negedge clk);
    trig = '0;
    // R10: leaving bypass shows no run was started
    wr(2'd0, cw(1, 0, 0, 0, 0, 3, 0));
    quiet("R10 no run", 6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule